// File: doc/BRIEF.md
# PLL Retune Sequencer

This block walks one PLL from its current setting to a new set of divisors without glitching the clock it feeds. A requester presents the input divider (NR), the feedback multiplier (NF) and the output divider (NO) with a one-cycle `req_valid`. The sequencer first checks that the request is legal. If it is, the sequencer drives a masked write port that updates the PLL's control words and its mode field. The sequence is:

1. park the PLL in slow bypass;
2. hold the PLL in reset;
3. load the divisor and loop-bandwidth fields;
4. wait a fixed settle time;
5. release reset;
6. poll the lock indication;
7. return the PLL to normal mode.

The block finishes with a one-cycle `done` or a one-cycle `error`.

States and transitions. `S_IDLE` goes to `S_CHECK` when a request arrives. `S_CHECK` goes to `S_SLOW` for a legal request and to `S_REJECT` for an illegal one. `S_REJECT` returns to `S_IDLE`. The main path is a fixed chain: `S_SLOW`, `S_RST_ON`, `S_CON0`, `S_CON1`, `S_CON2`, `S_SETTLE`. The sequencer leaves `S_SETTLE` when the interval timer expires, then passes through `S_RST_OFF` to `S_POLL`. `S_POLL` samples the lock input once per microsecond interval:
- When lock is seen, it goes to `S_NORMAL`, then to `S_DONE`, then to `S_IDLE`.
- After the last allowed sample without lock, it goes to `S_ABORT`, which re-parks the PLL in slow mode. It then goes to `S_FAIL` and back to `S_IDLE`.

Write port addresses are fixed:
- 0, 1, 2 and 3 select the four PLL control words.
- 4 selects the mode register.

Only the bits set in `wr_mask` change.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `busy`, `done`, `error` and `wr_en` are all 0.
- R2: A `req_valid` sampled while idle is accepted. `busy` is 1 from the next cycle through the cycle that carries `done` or `error`, and is 0 in the cycle after that.
- R3: A request is rejected unless all of the following hold: NR is 1 to 64, NO is 1 to 16, and NO is 1 or even.
- R4: A request is rejected unless REF_KHZ*NF/NR lies in 440000..2200000 kHz inclusive and REF_KHZ*NF/(NR*NO) is at least 27500 kHz.
- R5: A rejected request produces exactly one `error` pulse, no `done` and no write at all.
- R6: An accepted request produces writes in this order:
  - mode (addr 4, data 0x0000, mask 0x0003);
  - reset on (addr 3, data 0x0020, mask 0x0020);
  - word 0;
  - word 1;
  - word 2;
  - reset off (addr 3, data 0x0000, mask 0x0020);
  - mode normal (addr 4, data 0x0001, mask 0x0003).
- R7: Word 0 (addr 0, mask 0x3F0F) carries NR-1 in bits 13:8 and NO-1 in bits 3:0. Word 1 (addr 1, mask 0x1FFF) carries NF-1 in bits 12:0. Word 2 (addr 2, mask 0x0FFF) carries (NF>>1)-1 in bits 11:0. All other data bits are 0.
- R8: The reset-off write comes exactly SETTLE_US*CYC_PER_US+1 cycles after the word 2 write.
- R9: `pll_locked` is sampled every CYC_PER_US cycles after reset-off. The normal-mode write comes 1 to CYC_PER_US cycles after lock rises, and `done` follows it in the next cycle.
- R10: If LOCK_POLLS samples in a row miss lock, the sequencer does the following. Exactly LOCK_POLLS*CYC_PER_US+1 cycles after reset-off, it writes addr 4 with data 0x0000 and mask 0x0003. It then pulses `error` and makes no normal-mode write.
- R11: `req_valid` raised while `busy` is 1 has no effect on the writes, `done` or `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle retune request |
| req_nr | input | 7 | Input divider NR |
| req_nf | input | 13 | Feedback multiplier NF |
| req_no | input | 5 | Output divider NO |
| pll_locked | input | 1 | PLL lock indication |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle successful completion |
| error | output | 1 | One-cycle reject or lock timeout |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 3 | 0..3 control words, 4 mode register |
| wr_data | output | 16 | Write data |
| wr_mask | output | 16 | Bits of the target updated by this write |

## Verification
Divisor sets sit at and just past each legality edge, so the tests separate the inclusive VCO bounds and output floor from off-by-one comparisons:
- VCO exactly 440 MHz;
- VCO exactly 2200 MHz;
- output exactly 27.5 MHz with NO=16;
- NR=64 and NR=65;
- NO equal to 0, 3 and 18.

Legal sets with distinct NR, NF and NO values show whether each field lands at its own bit position with the minus-one encoding, and whether the bandwidth value is derived from NF.

A late-locking PLL model tells the poll interval apart from a fixed wait. A PLL that never locks exposes the abort path and its exact timeout. A request injected mid-sequence, and a reset mid-sequence, show whether a sequence in flight can be disturbed.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    // Request field widths
    parameter int NR_W = 7;
    parameter int NF_W = 13;
    parameter int NO_W = 5;

    // Write port geometry
    parameter int ADDR_W = 3;
    parameter int DATA_W = 16;

    // Field placement inside the control words
    parameter int NR_LSB  = 8;
    parameter int NR_FLD  = 6;
    parameter int NO_LSB  = 0;
    parameter int NO_FLD  = 4;
    parameter int NF_FLD  = 13;
    parameter int BW_FLD  = 12;
    parameter int RST_BIT = 5;
    parameter int MODE_FLD = 2;

    // Target addresses
    parameter logic [ADDR_W-1:0] A_CON0 = 3'd0;
    parameter logic [ADDR_W-1:0] A_CON1 = 3'd1;
    parameter logic [ADDR_W-1:0] A_CON2 = 3'd2;
    parameter logic [ADDR_W-1:0] A_CON3 = 3'd3;
    parameter logic [ADDR_W-1:0] A_MODE = 3'd4;

    // Mode encodings
    parameter logic [DATA_W-1:0] MODE_SLOW   = 16'h0000;
    parameter logic [DATA_W-1:0] MODE_NORMAL = 16'h0001;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_REJECT,
        S_SLOW,
        S_RST_ON,
        S_CON0,
        S_CON1,
        S_CON2,
        S_SETTLE,
        S_RST_OFF,
        S_POLL,
        S_NORMAL,
        S_DONE,
        S_ABORT,
        S_FAIL
    } seq_state_e;

    typedef struct packed {
        logic [NR_W-1:0] nr;
        logic [NF_W-1:0] nf;
        logic [NO_W-1:0] no;
    } div_req_t;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000,
    parameter int OUT_MIN_KHZ = 27500,
    parameter int NR_MAX      = 64,
    parameter int NO_MAX      = 16
) (
    input  div_req_t req,
    output logic     legal
);

    localparam int PW = 64;

    logic [PW-1:0] ref_prod;
    logic [PW-1:0] vco_lo;
    logic [PW-1:0] vco_hi;
    logic [PW-1:0] out_lo;
    logic          range_ok;
    logic          no_shape_ok;
    logic          freq_ok;

    always_comb begin
        // Cross-multiplied so no division is needed
        ref_prod = PW'(REF_KHZ) * PW'(req.nf);
        vco_lo   = PW'(VCO_MIN_KHZ) * PW'(req.nr);
        vco_hi   = PW'(VCO_MAX_KHZ) * PW'(req.nr);
        out_lo   = PW'(OUT_MIN_KHZ) * PW'(req.nr) * PW'(req.no);

        range_ok    = (req.nr != '0) && (int'(req.nr) <= NR_MAX) &&
                      (req.no != '0) && (int'(req.no) <= NO_MAX) &&
                      (req.nf != '0);
        no_shape_ok = (req.no == NO_W'(1)) || !req.no[0];
        freq_ok     = (ref_prod >= vco_lo) && (ref_prod <= vco_hi) &&
                      (ref_prod >= out_lo);

        legal = range_ok && no_shape_ok && freq_ok;
    end

endmodule

// File: rtl/pll_word_fmt.sv
module pll_word_fmt
    import pll_seq_pkg::*;
(
    input  div_req_t          req,
    output logic [DATA_W-1:0] con0,
    output logic [DATA_W-1:0] con1,
    output logic [DATA_W-1:0] con2
);

    logic [NR_W-1:0] nr_m1;
    logic [NO_W-1:0] no_m1;
    logic [NF_W-1:0] nf_m1;
    logic [NF_W-1:0] bw_val;

    always_comb begin
        nr_m1  = req.nr - NR_W'(1);
        no_m1  = req.no - NO_W'(1);
        nf_m1  = req.nf - NF_W'(1);
        bw_val = (req.nf >> 1) - NF_W'(1);

        con0 = '0;
        con0[NR_LSB +: NR_FLD] = nr_m1[NR_FLD-1:0];
        con0[NO_LSB +: NO_FLD] = no_m1[NO_FLD-1:0];

        con1 = '0;
        con1[NF_FLD-1:0] = nf_m1[NF_FLD-1:0];

        con2 = '0;
        con2[BW_FLD-1:0] = bw_val[BW_FLD-1:0];
    end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign hit = (cnt == limit - W'(1));

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ    = 24000,
    parameter int CYC_PER_US = 125,
    parameter int SETTLE_US  = 10,
    parameter int LOCK_POLLS = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NR_W-1:0]   req_nr,
    input  logic [NF_W-1:0]   req_nf,
    input  logic [NO_W-1:0]   req_no,
    input  logic              pll_locked,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wr_mask
);

    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int TMR_MAX    = (SETTLE_CYC > CYC_PER_US) ? SETTLE_CYC : CYC_PER_US;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int TRY_W      = $clog2(LOCK_POLLS + 1);

    localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'((1 << MODE_FLD) - 1);
    localparam logic [DATA_W-1:0] RST_MASK  = DATA_W'(1) << RST_BIT;
    localparam logic [DATA_W-1:0] CON0_MASK =
        (DATA_W'((1 << NR_FLD) - 1) << NR_LSB) | (DATA_W'((1 << NO_FLD) - 1) << NO_LSB);
    localparam logic [DATA_W-1:0] CON1_MASK = DATA_W'((1 << NF_FLD) - 1);
    localparam logic [DATA_W-1:0] CON2_MASK = DATA_W'((1 << BW_FLD) - 1);

    seq_state_e state;
    seq_state_e nxt;

    div_req_t          req_q;
    logic              legal;
    logic [DATA_W-1:0] con0_w;
    logic [DATA_W-1:0] con1_w;
    logic [DATA_W-1:0] con2_w;

    logic              tmr_clear;
    logic              tmr_hit;
    logic [TMR_W-1:0]  tmr_limit;
    logic [TRY_W-1:0]  tries_q;
    logic              try_last;

    // ---------------- datapath pieces ----------------
    pll_req_check #(
        .REF_KHZ (REF_KHZ)
    ) u_check (
        .req   (req_q),
        .legal (legal)
    );

    pll_word_fmt u_fmt (
        .req  (req_q),
        .con0 (con0_w),
        .con1 (con1_w),
        .con2 (con2_w)
    );

    assign tmr_limit = (state == S_SETTLE) ? TMR_W'(SETTLE_CYC) : TMR_W'(CYC_PER_US);
    assign tmr_clear = !((state == S_SETTLE) || (state == S_POLL)) ||
                       ((state == S_POLL) && tmr_hit);

    pll_seq_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    assign try_last = (tries_q == TRY_W'(LOCK_POLLS - 1));

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_CHECK;
            S_CHECK:   nxt = legal ? S_SLOW : S_REJECT;
            S_REJECT:  nxt = S_IDLE;
            S_SLOW:    nxt = S_RST_ON;
            S_RST_ON:  nxt = S_CON0;
            S_CON0:    nxt = S_CON1;
            S_CON1:    nxt = S_CON2;
            S_CON2:    nxt = S_SETTLE;
            S_SETTLE:  if (tmr_hit) nxt = S_RST_OFF;
            S_RST_OFF: nxt = S_POLL;
            S_POLL: begin
                if (tmr_hit) begin
                    if (pll_locked) begin
                        nxt = S_NORMAL;
                    end else if (try_last) begin
                        nxt = S_ABORT;
                    end
                end
            end
            S_NORMAL:  nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            S_ABORT:   nxt = S_FAIL;
            S_FAIL:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            req_q   <= '0;
            tries_q <= '0;
        end else begin
            state <= nxt;
            if ((state == S_IDLE) && req_valid) begin
                req_q.nr <= req_nr;
                req_q.nf <= req_nf;
                req_q.no <= req_no;
            end
            if (state != S_POLL) begin
                tries_q <= '0;
            end else if (tmr_hit && !pll_locked) begin
                tries_q <= tries_q + TRY_W'(1);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy    = (state != S_IDLE);
        done    = 1'b0;
        error   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        wr_mask = '0;
        unique case (state)
            S_SLOW, S_ABORT: begin
                wr_en   = 1'b1;
                wr_addr = A_MODE;
                wr_data = MODE_SLOW;
                wr_mask = MODE_MASK;
            end
            S_RST_ON: begin
                wr_en   = 1'b1;
                wr_addr = A_CON3;
                wr_data = RST_MASK;
                wr_mask = RST_MASK;
            end
            S_CON0: begin
                wr_en   = 1'b1;
                wr_addr = A_CON0;
                wr_data = con0_w;
                wr_mask = CON0_MASK;
            end
            S_CON1: begin
                wr_en   = 1'b1;
                wr_addr = A_CON1;
                wr_data = con1_w;
                wr_mask = CON1_MASK;
            end
            S_CON2: begin
                wr_en   = 1'b1;
                wr_addr = A_CON2;
                wr_data = con2_w;
                wr_mask = CON2_MASK;
            end
            S_RST_OFF: begin
                wr_en   = 1'b1;
                wr_addr = A_CON3;
                wr_data = '0;
                wr_mask = RST_MASK;
            end
            S_NORMAL: begin
                wr_en   = 1'b1;
                wr_addr = A_MODE;
                wr_data = MODE_NORMAL;
                wr_mask = MODE_MASK;
            end
            S_DONE:             done  = 1'b1;
            S_REJECT, S_FAIL:   error = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        pll_locked,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [15:0] wr_data
);

    // R1: nothing leaves the block while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !done && !error));

    // R2: an idle request starts a sequence
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R2: busy drops right after the closing pulse
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !busy);

    // R5: a sequence never ends both ways
    a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R9: the normal-mode write follows a lock sample
    a_r9_lock_before_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4 && wr_data[1:0] == 2'd1) |-> $past(pll_locked));

    // R9: completion follows the normal-mode write
    a_r9_done_after_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4 && wr_data[1:0] == 2'd1) |=> done);

endmodule

bind pll_retune_seq pll_retune_seq_chk u_chk (.*);

// File: tb/pll_retune_seq_test.sv
module pll_retune_seq_test;

    localparam int CPU      = 4;
    localparam int SUS      = 10;
    localparam int NPOLL    = 6;
    localparam int LOCK_DLY = 9;
    localparam int SETTLE   = SUS * CPU;
    localparam int NVEC     = 13;

    typedef struct packed {
        logic [6:0]  nr;
        logic [12:0] nf;
        logic [4:0]  no;
        logic        ok;
        logic [15:0] c0;
        logic [15:0] c1;
        logic [15:0] c2;
    } vec_t;

    // REF 24 MHz; expected words worked out by hand from R7
    localparam vec_t VECS [NVEC] = '{
        '{7'd1,  13'd75,   5'd1,  1'b1, 16'h0000, 16'h004A, 16'h0024},
        '{7'd2,  13'd100,  5'd2,  1'b1, 16'h0101, 16'h0063, 16'h0031},
        '{7'd9,  13'd400,  5'd2,  1'b1, 16'h0801, 16'h018F, 16'h00C7},
        '{7'd3,  13'd55,   5'd16, 1'b1, 16'h020F, 16'h0036, 16'h001A},
        '{7'd3,  13'd275,  5'd1,  1'b1, 16'h0200, 16'h0112, 16'h0088},
        '{7'd64, 13'd1200, 5'd2,  1'b1, 16'h3F01, 16'h04AF, 16'h0257},
        '{7'd1,  13'd75,   5'd3,  1'b0, 16'h0000, 16'h0000, 16'h0000},
        '{7'd3,  13'd54,   5'd1,  1'b0, 16'h0000, 16'h0000, 16'h0000},
        '{7'd3,  13'd276,  5'd1,  1'b0, 16'h0000, 16'h0000, 16'h0000},
        '{7'd65, 13'd1200, 5'd2,  1'b0, 16'h0000, 16'h0000, 16'h0000},
        '{7'd0,  13'd75,   5'd1,  1'b0, 16'h0000, 16'h0000, 16'h0000},
        '{7'd1,  13'd75,   5'd18, 1'b0, 16'h0000, 16'h0000, 16'h0000},
        '{7'd1,  13'd75,   5'd0,  1'b0, 16'h0000, 16'h0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_nr = '0;
    logic [12:0] req_nf = '0;
    logic [4:0]  req_no = '0;
    logic        pll_locked = 1'b0;
    logic        busy, done, error, wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data, wr_mask;

    pll_retune_seq #(
        .REF_KHZ    (24000),
        .CYC_PER_US (CPU),
        .SETTLE_US  (SUS),
        .LOCK_POLLS (NPOLL)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_nr     (req_nr),
        .req_nf     (req_nf),
        .req_no     (req_no),
        .pll_locked (pll_locked),
        .busy       (busy),
        .done       (done),
        .error      (error),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;

    // write log and lock model, sampled mid-cycle
    logic [2:0]  la [256];
    logic [15:0] ld [256];
    logic [15:0] lm [256];
    int          lc [256];
    int nlog = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int done_cyc = 0;
    int lock_cyc = 0;
    int lock_cd = -1;
    bit lock_en = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en && nlog < 256) begin
                la[nlog] = wr_addr;
                ld[nlog] = wr_data;
                lm[nlog] = wr_mask;
                lc[nlog] = cyc;
                nlog++;
                if (wr_addr == 3'd3 && wr_mask[5] && !wr_data[5] && lock_en)
                    lock_cd = LOCK_DLY;
                if (wr_addr == 3'd4 && wr_data[1:0] == 2'd0) begin
                    pll_locked = 1'b0;
                    lock_cd = -1;
                end
            end
            if (lock_cd > 0) begin
                lock_cd--;
                if (lock_cd == 0) begin
                    pll_locked = 1'b1;
                    lock_cyc = cyc;
                    lock_cd = -1;
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (error) err_cnt++;
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!cond) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_entry(input int i, input logic [2:0] a, input logic [15:0] d,
                             input logic [15:0] m, input string req, input string what);
        chk(la[i] == a, req, {what, " addr"}, int'(la[i]), int'(a));
        chk(ld[i] == d && lm[i] == m, req, {what, " data/mask"},
            int'({ld[i], lm[i]}), int'({d, m}));
    endtask

    // Issue one request and wait until the sequence closes
    task automatic issue(input vec_t v, input bit inject);
        int t;
        int d0;
        int e0;
        d0 = done_cnt;
        e0 = err_cnt;
        @(negedge clk); #1;
        req_nr = v.nr; req_nf = v.nf; req_no = v.no; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
        t = 0;
        while (done_cnt == d0 && err_cnt == e0 && t < 5000) begin
            if (inject && (t == 20 || t == 50)) begin
                req_nr = 7'd1; req_nf = 13'd75; req_no = 5'd3; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk); #1;
            t++;
        end
        req_valid = 1'b0;
        chk(t < 5000, "R2", "sequence closes", t, 0);
        chk(busy == 1'b1, "R2", "busy during closing pulse", int'(busy), 1);
        @(negedge clk); #1;
        chk(busy == 1'b0, "R2", "busy after close", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        int base;
        int d0;
        int e0;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !error && !wr_en, "R1", "outputs in reset",
            int'({busy, done, error, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !done && !error && !wr_en, "R1", "outputs after reset",
            int'({busy, done, error, wr_en}), 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            base = nlog;
            d0 = done_cnt;
            e0 = err_cnt;
            issue(VECS[i], i == 0);
            if (VECS[i].ok) begin
                chk(done_cnt - d0 == 1 && err_cnt == e0, "R3 R4", "accepted",
                    err_cnt - e0, 0);
                chk(nlog - base == 7, "R6", "write count", nlog - base, 7);
                chk_entry(base + 0, 3'd4, 16'h0000, 16'h0003, "R6", "slow mode");
                chk_entry(base + 1, 3'd3, 16'h0020, 16'h0020, "R6", "reset on");
                chk_entry(base + 2, 3'd0, VECS[i].c0, 16'h3F0F, "R7", "word 0");
                chk_entry(base + 3, 3'd1, VECS[i].c1, 16'h1FFF, "R7", "word 1");
                chk_entry(base + 4, 3'd2, VECS[i].c2, 16'h0FFF, "R7", "word 2");
                chk_entry(base + 5, 3'd3, 16'h0000, 16'h0020, "R6", "reset off");
                chk_entry(base + 6, 3'd4, 16'h0001, 16'h0003, "R6", "normal mode");
                chk(lc[base + 5] - lc[base + 4] == SETTLE + 1, "R8", "settle gap",
                    lc[base + 5] - lc[base + 4], SETTLE + 1);
                chk(lc[base + 6] - lock_cyc >= 1 && lc[base + 6] - lock_cyc <= CPU,
                    "R9", "lock to normal", lc[base + 6] - lock_cyc, CPU);
                chk(done_cyc == lc[base + 6] + 1, "R9", "done after normal",
                    done_cyc, lc[base + 6] + 1);
                if (i == 0) begin
                    chk(err_cnt == e0 && nlog - base == 7, "R11",
                        "request while busy ignored", err_cnt - e0, 0);
                end
            end else begin
                chk(err_cnt - e0 == 1 && done_cnt == d0, "R3 R4", "rejected",
                    err_cnt - e0, 1);
                chk(nlog == base, "R5", "no writes on reject", nlog - base, 0);
            end
        end

        // lock never arrives
        lock_en = 1'b0;
        base = nlog;
        d0 = done_cnt;
        e0 = err_cnt;
        issue(VECS[1], 1'b0);
        chk(err_cnt - e0 == 1 && done_cnt == d0, "R10", "timeout error",
            err_cnt - e0, 1);
        chk(nlog - base == 7, "R10", "timeout write count", nlog - base, 7);
        chk_entry(base + 6, 3'd4, 16'h0000, 16'h0003, "R10", "re-park slow");
        chk(lc[base + 6] - lc[base + 5] == NPOLL * CPU + 1, "R10", "timeout gap",
            lc[base + 6] - lc[base + 5], NPOLL * CPU + 1);
        lock_en = 1'b1;

        // reset in the middle of a sequence
        @(negedge clk); #1;
        req_nr = 7'd2; req_nf = 13'd100; req_no = 5'd2; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk(!busy && !wr_en && !done && !error, "R1", "mid-sequence reset",
            int'({busy, wr_en, done, error}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !wr_en, "R1", "idle after reset release",
            int'({busy, wr_en}), 0);

        // a fresh sequence still completes after the reset
        base = nlog;
        issue(VECS[2], 1'b0);
        chk(nlog - base == 7, "R6", "sequence after reset", nlog - base, 7);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule